// File: doc/BRIEF.md
# Floating-Point Special-Operand Bypass Detector

This block sits beside a single-precision arithmetic unit and inspects each operation before the normal datapath produces a result. It sorts every operand it reads into zero, finite nonzero (normal or subnormal), infinity, quiet NaN or signaling NaN. From those classes and the opcode it decides whether the result is fixed by special-case rules alone. When it is, the block raises a bypass strobe and presents the finished 32-bit result. The surrounding unit then writes that result in place of the datapath output.

Alongside the per-operation flags for invalid operation and division by zero, the block keeps two cumulative status bits. They collect every flag raised since they were last cleared, and a software write replaces them. Finite arithmetic and rounding stay in the datapath; this block only claims operations whose answer is a NaN, an infinity or, for a finite value divided by infinity, a signed zero.

Top module: `fp_special_detect`

## Requirements
- R1: When any operand read by the operation is a NaN, the bypass result is the first such operand in the order A, B, C, with fraction bit 22 forced to 1 (quieted). The exponent field is bits 30:23, and a NaN has exponent all ones with a nonzero fraction.
- R2: A NaN returned under R1 raises the invalid flag exactly when some operand read by the operation is a signaling NaN, meaning fraction bit 22 is 0. Quiet NaNs alone raise no flag.
- R3: The following cases return 0x7FC00000 with the invalid flag set and the divide-by-zero flag clear: add of opposite-signed infinities, subtract of like-signed infinities, multiply of zero by infinity in either order, divide of zero by zero or infinity by infinity, and square root of any negative nonzero value including negative infinity.
- R4: Divide of a finite nonzero dividend by a zero of either sign returns infinity with sign A xor B, sets divide-by-zero and leaves invalid clear. Reciprocal treats the dividend as +1.0, so a zero operand A returns infinity with the sign of A and sets divide-by-zero.
- R5: Any other operation involving an infinity bypasses with a correctly signed infinity and no flag. Subtract uses the inverted sign of B, multiply and divide use sign A xor B, and square root of +infinity gives +infinity. A finite value divided by infinity, and the reciprocal of infinity, give a zero carrying the sign of the quotient.
- R6: Fused multiply-add computes A*B+C. It is invalid (0x7FC00000) when A*B is zero times infinity, or when A*B is infinite and C is an infinity whose sign differs from A xor B. Otherwise an infinite product gives infinity with sign A xor B, and an infinite C with a finite product gives C.
- R7: The opcode encoding is 0 add, 1 subtract, 2 multiply, 3 divide, 4 square root of A, 5 fused multiply-add, 6 reciprocal of A, and 7 unused. The operation reads A and B for opcodes 0 to 3, A alone for 4 and 6, and all three for 5. No bypass and no flag are produced when in_valid is low, for opcode 7, or for cases not listed above.
- R8: Each status bit (bit 0 invalid, bit 1 divide-by-zero) is set on the clock edge after its flag is raised with in_valid high, and stays set until a write clears it. The status bits reset to 0.
- R9: A write (sts_wr high) loads the status bits from sts_wdata on the next edge. A flag raised in the same cycle is ORed in, so it is never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| src_c | input | 32 | Operand C (addend for fused multiply-add) |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Status write value, bit 0 invalid, bit 1 divide-by-zero |
| byp_valid | output | 1 | Special result replaces datapath result |
| byp_result | output | 32 | Special result |
| flag_inv | output | 1 | Invalid operation for this operation |
| flag_dz | output | 1 | Division by zero for this operation |
| sticky_inv | output | 1 | Cumulative invalid status |
| sticky_dz | output | 1 | Cumulative divide-by-zero status |

## Verification
Every opcode, including the unused one, is swept with every combination of twelve operand values. The set covers both signed zeros, normal and subnormal values of each sign, both infinities, and quiet and signaling NaNs of each sign, so all three operands meet every class. The sweep separates NaN priority from operation rules, divide-by-zero from invalid divide, and signed zero from infinity in quotients. It also catches product-versus-addend sign errors in fused multiply-add. During the sweep, in_valid is periodically dropped and status writes of varying values are interleaved, so that clearing, holding and same-cycle collisions of the status bits are all compared against a bench model.

// File: rtl/fp_special_detect.sv
module fp_special_detect #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_c,
  input  logic         sts_wr,
  input  logic [1:0]   sts_wdata,
  output logic         byp_valid,
  output logic [W-1:0] byp_result,
  output logic         flag_inv,
  output logic         flag_dz,
  output logic         sticky_inv,
  output logic         sticky_dz
);

  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_DIV = 3'd3,
                         OP_SQRT = 3'd4, OP_FMA = 3'd5, OP_RCP = 3'd6;
  localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic [W-1:0] mk_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] mk_zero(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  logic [W-1:0] opnd [3];
  logic [2:0] is_nan, is_snan, is_inf, is_zero, sgn, used, nan_u;

  assign opnd[0] = src_a;
  assign opnd[1] = src_b;
  assign opnd[2] = src_c;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      is_nan[i]  = (&opnd[i][W-2:MAN_W]) && (|opnd[i][MAN_W-1:0]);
      is_snan[i] = is_nan[i] && !opnd[i][MAN_W-1];
      is_inf[i]  = (&opnd[i][W-2:MAN_W]) && !(|opnd[i][MAN_W-1:0]);
      is_zero[i] = !(|opnd[i][W-2:0]);
      sgn[i]     = opnd[i][W-1];
    end
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: used = 3'b011;
      OP_SQRT, OP_RCP:                used = 3'b001;
      OP_FMA:                         used = 3'b111;
      default:                        used = 3'b000;
    endcase
  end

  assign nan_u = is_nan & used;

  logic         byp, inv, dz, sb_eff, sp, prod_zi, prod_inf;
  logic [W-1:0] res;

  assign sb_eff   = sgn[1] ^ (op == OP_SUB);
  assign sp       = sgn[0] ^ sgn[1];
  assign prod_zi  = (is_zero[0] && is_inf[1]) || (is_inf[0] && is_zero[1]);
  assign prod_inf = is_inf[0] || is_inf[1];

  always_comb begin
    byp = 1'b0;
    inv = 1'b0;
    dz  = 1'b0;
    res = '0;
    if (|nan_u) begin
      byp = 1'b1;
      inv = |(is_snan & used);
      if (nan_u[0])      res = src_a;
      else if (nan_u[1]) res = src_b;
      else               res = src_c;
      res[MAN_W-1] = 1'b1;
    end else begin
      case (op)
        OP_ADD, OP_SUB: begin
          if (is_inf[0] && is_inf[1]) begin
            byp = 1'b1;
            if (sgn[0] != sb_eff) begin
              inv = 1'b1;
              res = DEF_QNAN;
            end else res = mk_inf(sgn[0]);
          end else if (is_inf[0]) begin
            byp = 1'b1;
            res = mk_inf(sgn[0]);
          end else if (is_inf[1]) begin
            byp = 1'b1;
            res = mk_inf(sb_eff);
          end
        end
        OP_MUL: begin
          if (prod_zi) begin
            byp = 1'b1;
            inv = 1'b1;
            res = DEF_QNAN;
          end else if (prod_inf) begin
            byp = 1'b1;
            res = mk_inf(sp);
          end
        end
        OP_DIV: begin
          if ((is_zero[0] && is_zero[1]) || (is_inf[0] && is_inf[1])) begin
            byp = 1'b1;
            inv = 1'b1;
            res = DEF_QNAN;
          end else if (is_inf[0]) begin
            byp = 1'b1;
            res = mk_inf(sp);
          end else if (is_inf[1]) begin
            byp = 1'b1;
            res = mk_zero(sp);
          end else if (is_zero[1]) begin
            byp = 1'b1;
            dz  = 1'b1;
            res = mk_inf(sp);
          end
        end
        OP_RCP: begin
          if (is_zero[0]) begin
            byp = 1'b1;
            dz  = 1'b1;
            res = mk_inf(sgn[0]);
          end else if (is_inf[0]) begin
            byp = 1'b1;
            res = mk_zero(sgn[0]);
          end
        end
        OP_SQRT: begin
          if (sgn[0] && !is_zero[0]) begin
            byp = 1'b1;
            inv = 1'b1;
            res = DEF_QNAN;
          end else if (is_inf[0]) begin
            byp = 1'b1;
            res = mk_inf(1'b0);
          end
        end
        OP_FMA: begin
          if (prod_zi || (prod_inf && is_inf[2] && (sgn[2] != sp))) begin
            byp = 1'b1;
            inv = 1'b1;
            res = DEF_QNAN;
          end else if (prod_inf) begin
            byp = 1'b1;
            res = mk_inf(sp);
          end else if (is_inf[2]) begin
            byp = 1'b1;
            res = mk_inf(sgn[2]);
          end
        end
        default: ;
      endcase
    end
  end

  assign byp_valid  = in_valid && byp;
  assign byp_result = (in_valid && byp) ? res : '0;
  assign flag_inv   = in_valid && inv;
  assign flag_dz    = in_valid && dz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_inv <= 1'b0;
      sticky_dz  <= 1'b0;
    end else begin
      sticky_inv <= (sts_wr ? sts_wdata[0] : sticky_inv) | flag_inv;
      sticky_dz  <= (sts_wr ? sts_wdata[1] : sticky_dz)  | flag_dz;
    end
  end

endmodule

// File: rtl/fp_special_detect_chk.sv
module fp_special_detect_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [W-1:0] src_c,
  input logic         sts_wr,
  input logic [1:0]   sts_wdata,
  input logic         byp_valid,
  input logic [W-1:0] byp_result,
  input logic         flag_inv,
  input logic         flag_dz,
  input logic         sticky_inv,
  input logic         sticky_dz
);

  // R1
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && (&byp_result[W-2:MAN_W]) && (|byp_result[MAN_W-1:0])) |-> byp_result[MAN_W-1]);

  // R3
  flag_needs_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_inv || flag_dz) |-> byp_valid);

  // R4
  dz_is_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_dz |-> (!flag_inv && byp_result[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || op == 3'd7) |-> (!byp_valid && !flag_inv && !flag_dz));

  // R8
  inv_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |=> sticky_inv);

  // R8
  dz_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_dz |=> sticky_dz);

  // R9
  inv_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_inv) |-> ($past(sts_wr) && !$past(sts_wdata[0])));

  // R9
  dz_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_dz) |-> ($past(sts_wr) && !$past(sts_wdata[1])));

endmodule

bind fp_special_detect fp_special_detect_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_chk (.*);

// File: tb/test_fp_special_detect.sv
module test_fp_special_detect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic        sts_wr = 1'b0;
  logic [1:0]  sts_wdata = '0;
  logic        byp_valid, flag_inv, flag_dz, sticky_inv, sticky_dz;
  logic [31:0] byp_result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  fp_special_detect i_fp_special_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .byp_valid(byp_valid), .byp_result(byp_result),
    .flag_inv(flag_inv), .flag_dz(flag_dz),
    .sticky_inv(sticky_inv), .sticky_dz(sticky_dz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit f_nan(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
  function automatic bit f_snan(input logic [31:0] x); return f_nan(x) && !x[22]; endfunction
  function automatic bit f_inf(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] == 0; endfunction
  function automatic bit f_zero(input logic [31:0] x); return x[30:0] == 0; endfunction
  function automatic logic [31:0] inf_of(input bit s);  return {s, 31'h7F800000}; endfunction

  localparam logic [31:0] QN = 32'h7FC00000;

  // returns {bypass, result, invalid, dz}
  function automatic logic [34:0] ref_model(input logic [2:0] o, input logic [31:0] a, b, c,
                                            output string tag);
    logic [31:0] opv [3];
    bit use_v [3];
    bit any_s;
    bit sa, sb, sc, sq;
    opv[0] = a; opv[1] = b; opv[2] = c;
    use_v[0] = (o != 3'd7);
    use_v[1] = (o <= 3'd3) || (o == 3'd5);
    use_v[2] = (o == 3'd5);
    any_s = 0;
    for (int k = 0; k < 3; k++) if (use_v[k] && f_snan(opv[k])) any_s = 1;
    for (int k = 0; k < 3; k++)
      if (use_v[k] && f_nan(opv[k])) begin
        tag = any_s ? "R2" : "R1";
        return {1'b1, opv[k] | 32'h00400000, any_s, 1'b0};
      end
    sa = a[31]; sb = b[31]; sc = c[31]; sq = sa ^ sb;
    tag = "R7";
    case (o)
      3'd0, 3'd1: begin
        bit eb;
        eb = sb ^ (o == 3'd1);
        if (f_inf(a) && f_inf(b) && sa != eb) begin tag = "R3"; return {1'b1, QN, 2'b10}; end
        if (f_inf(a)) begin tag = "R5"; return {1'b1, inf_of(sa), 2'b00}; end
        if (f_inf(b)) begin tag = "R5"; return {1'b1, inf_of(eb), 2'b00}; end
      end
      3'd2: begin
        if ((f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b))) begin tag = "R3"; return {1'b1, QN, 2'b10}; end
        if (f_inf(a) || f_inf(b)) begin tag = "R5"; return {1'b1, inf_of(sq), 2'b00}; end
      end
      3'd3: begin
        if ((f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b))) begin tag = "R3"; return {1'b1, QN, 2'b10}; end
        if (f_inf(a)) begin tag = "R5"; return {1'b1, inf_of(sq), 2'b00}; end
        if (f_inf(b)) begin tag = "R5"; return {1'b1, {sq, 31'h0}, 2'b00}; end
        if (f_zero(b)) begin tag = "R4"; return {1'b1, inf_of(sq), 2'b01}; end
      end
      3'd4: begin
        if (sa && !f_zero(a)) begin tag = "R3"; return {1'b1, QN, 2'b10}; end
        if (f_inf(a)) begin tag = "R5"; return {1'b1, inf_of(1'b0), 2'b00}; end
      end
      3'd5: begin
        bit pz, pi;
        pz = (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
        pi = f_inf(a) || f_inf(b);
        if (pz || (pi && f_inf(c) && sc != sq)) begin tag = "R6"; return {1'b1, QN, 2'b10}; end
        if (pi) begin tag = "R6"; return {1'b1, inf_of(sq), 2'b00}; end
        if (f_inf(c)) begin tag = "R6"; return {1'b1, inf_of(sc), 2'b00}; end
      end
      3'd6: begin
        if (f_zero(a)) begin tag = "R4"; return {1'b1, inf_of(sa), 2'b01}; end
        if (f_inf(a)) begin tag = "R5"; return {1'b1, {sa, 31'h0}, 2'b00}; end
      end
      default: ;
    endcase
    return 35'h0;
  endfunction

  logic [31:0] vals [12];
  initial begin
    vals[0] = 32'h00000000; vals[1] = 32'h80000000; vals[2]  = 32'h3F800000; vals[3]  = 32'hBFC00000;
    vals[4] = 32'h00000001; vals[5] = 32'h807FFFFF; vals[6]  = 32'h7F800000; vals[7]  = 32'hFF800000;
    vals[8] = 32'h7FC00001; vals[9] = 32'hFFD00000; vals[10] = 32'h7F800001; vals[11] = 32'hFFA00000;
  end

  task automatic check(input string req, input logic [34:0] got, input logic [34:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h c=%h actual=%h expected=%h", req, op, src_a, src_b, src_c, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_st;
    int n;
    exp_st = 2'b00;
    n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8", {33'h0, sticky_dz, sticky_inv}, 35'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int o = 0; o < 8; o++)
      for (int ia = 0; ia < 12; ia++)
        for (int ib = 0; ib < 12; ib++)
          for (int ic = 0; ic < 12; ic++) begin
            logic [34:0] exp_v;
            string tag, stag;
            @(negedge clk);
            n++;
            op = o[2:0];
            src_a = vals[ia]; src_b = vals[ib]; src_c = vals[ic];
            in_valid = (n % 11) != 0;
            sts_wr = (n % 29) == 0;
            sts_wdata = n[6:5];
            exp_v = ref_model(op, src_a, src_b, src_c, tag);
            if (!in_valid) begin exp_v = 35'h0; tag = "R7"; end
            #1;
            check(tag, {byp_valid, byp_result, flag_inv, flag_dz}, exp_v);
            exp_st = (sts_wr ? sts_wdata : exp_st) | {exp_v[0], exp_v[1]};
            stag = sts_wr ? "R9" : "R8";
            @(posedge clk);
            #1;
            check(stag, {33'h0, sticky_dz, sticky_inv}, {33'h0, exp_st});
          end

    // R9 explicit clear with no flags, then hold
    @(negedge clk);
    in_valid = 1'b0; sts_wr = 1'b1; sts_wdata = 2'b00;
    @(posedge clk); #1;
    check("R9", {33'h0, sticky_dz, sticky_inv}, 35'h0);
    @(negedge clk);
    sts_wr = 1'b0; in_valid = 1'b1; op = 3'd3; src_a = 32'h3F800000; src_b = 32'h80000000;
    @(posedge clk); #1;
    check("R8", {33'h0, sticky_dz, sticky_inv}, {33'h0, 2'b10});
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8", {33'h0, sticky_dz, sticky_inv}, {33'h0, 2'b10});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule